// File: doc/BRIEF.md
# Board control register file

This block is the bus-facing control logic of a development board. A bus master reaches it over a simple 32-bit single-cycle request interface. It keeps a small set of board registers: an LED bar, an eight-character ASCII display buffer, a break value, a general-purpose output byte and the lines of a bit-banged I2C port. It also reports a fixed switch value and a status word that gives the configured byte order.

Only the low address bits are decoded, so the register window repeats across the upper address space. The display can be loaded one character at a time, or all at once from a 32-bit word that the block renders as upper-case hexadecimal text. A write of a fixed magic value to the soft-reset register raises a one-cycle reset request for the system. The I2C port drives SCL and SDA from a register and reads the live SDA line of the attached device back through an input register.

Top module: `brd_ctrl_regs`

## Requirements
- R1: Only the low DEC_W (default 20) address bits are decoded; accesses that differ only in higher address bits reach the same register.
- R2: A read from an offset with no register returns zero, and a write to such an offset (including a misaligned offset inside the character window, such as 0x41C) changes no register or output.
- R3: `rd_valid` is high for exactly the cycle after each read request and low otherwise, with `rd_data` carrying the read value in that cycle.
- R4: Offset 0x200 always reads zero; offset 0x208 reads 0x12 when BIG_ENDIAN is 1 and 0x10 when it is 0.
- R5: A write to 0x408 stores the low 8 data bits on `led_bar`, and a read of 0x408 returns them zero-extended.
- R6: A write to 0x410 fills all eight display positions with the upper-case hex ASCII digits of the data word, most significant nibble in position 0; position i sits at `disp_text[8*i+7:8*i]`.
- R7: A write to offset 0x418 + 8*k (k = 0..7) stores the low data byte in display position k and leaves the other positions unchanged.
- R8: A write of exactly 0x00000042 to 0x500 drives `soft_rst_req` high for one cycle, in the cycle after the write; any other value written there gives no pulse.
- R9: 0x508 is an 8-bit break register (reset 0x0A) on `brk_val`, and 0xA00 is an 8-bit general-purpose output (reset 0x00) on `gp_out`; both read back zero-extended.
- R10: 0xB10 stores the whole data word and reads it back, with bit 1 driving `scl_out` and bit 0 driving `sda_out`; 0xB08 keeps 2 bits on `i2c_oe`; 0xB18 keeps 1 select bit.
- R11: A read of 0xB00 returns 0x2 with bit 0 replaced by the live `sda_in`; writes there are ignored.
- R12: A read of 0xA08 returns the 0xB10 register when the select bit is 1, and zero when it is 0.
- R13: After reset `led_bar` is 0, every display position holds 0x20 (space), the I2C output register is 0x3, select is 1, `i2c_oe` is 0 and `soft_rst_req` is 0.
- R14: `disp_upd` is high for exactly the cycle after any write to 0x410 or to a valid character offset, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request in this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | DATA_W | Read data |
| led_bar | output | 8 | LED bar value |
| disp_text | output | 8*N_CHARS | Display characters, position 0 in the low byte |
| disp_upd | output | 1 | Display changed strobe |
| soft_rst_req | output | 1 | Soft reset request pulse |
| brk_val | output | 8 | Break register value |
| gp_out | output | 8 | General-purpose output |
| scl_out | output | 1 | I2C clock line value |
| sda_out | output | 1 | I2C data line value |
| i2c_oe | output | 2 | I2C output-enable bits |
| sda_in | input | 1 | Live SDA from the I2C device |

## Verification
The hex rendering is tried with words that mix digits and letters in both orders (0x0123ABCD, 0xFEDC9876), which separates nibble order errors from an off-by-one in the letter offset; a single character write afterwards shows whether the per-position enable touches only its own slot. The soft-reset register is written with a near miss, a value equal in its low byte only, and the magic value, telling a full-word compare from a partial one. Aliased addresses with high bits set, a misaligned offset inside the character window and an unmapped neighbour of the LED register distinguish a correct low-bit decode from a loose one, and the I2C readbacks are taken with select both set and cleared and with SDA at both levels.

// File: rtl/brd_ctrl_pkg.sv
package brd_ctrl_pkg;
   // Register offsets inside the decoded window
   localparam int OFF_SWITCH  = 'h200;
   localparam int OFF_STATUS  = 'h208;
   localparam int OFF_LED     = 'h408;
   localparam int OFF_HEXWORD = 'h410;
   localparam int OFF_CHAR0   = 'h418;
   localparam int CHAR_STRIDE = 8;
   localparam int OFF_SOFTRST = 'h500;
   localparam int OFF_BREAK   = 'h508;
   localparam int OFF_GPO     = 'hA00;
   localparam int OFF_GPI     = 'hA08;
   localparam int OFF_I2C_IN  = 'hB00;
   localparam int OFF_I2C_OE  = 'hB08;
   localparam int OFF_I2C_OUT = 'hB10;
   localparam int OFF_I2C_SEL = 'hB18;

   localparam logic [7:0] SOFT_MAGIC  = 8'h42;
   localparam logic [7:0] BREAK_RST   = 8'h0A;
   localparam logic [7:0] SPACE_CHAR  = 8'h20;
   localparam logic [1:0] I2C_IN_RST  = 2'b11;
   localparam logic [1:0] I2C_OUT_RST = 2'b11;

   function automatic logic [7:0] nib2ascii(input logic [3:0] n);
      return (n < 4'd10) ? (8'h30 + {4'h0, n}) : (8'h41 + {4'h0, n} - 8'd10);
   endfunction
endpackage

// File: rtl/brd_hex_fmt.sv
module brd_hex_fmt #(
   parameter int N_CHARS = 8
) (
   input  logic [4*N_CHARS-1:0] word,
   output logic [8*N_CHARS-1:0] chars
);
   import brd_ctrl_pkg::*;

   // Position 0 takes the most significant nibble
   for (genvar i = 0; i < N_CHARS; i++) begin : g_pos
      assign chars[8*i +: 8] = nib2ascii(word[4*(N_CHARS-1-i) +: 4]);
   end
endmodule

// File: rtl/brd_disp_buf.sv
module brd_disp_buf #(
   parameter int N_CHARS = 8,
   localparam int IDX_W = $clog2(N_CHARS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 hex_ld,
   input  logic [8*N_CHARS-1:0] hex_chars,
   input  logic                 chr_ld,
   input  logic [IDX_W-1:0]     chr_idx,
   input  logic [7:0]           chr_byte,
   output logic [8*N_CHARS-1:0] text,
   output logic                 upd
);
   import brd_ctrl_pkg::*;

   for (genvar i = 0; i < N_CHARS; i++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            text[8*i +: 8] <= SPACE_CHAR;
         else if (hex_ld)
            text[8*i +: 8] <= hex_chars[8*i +: 8];
         else if (chr_ld && chr_idx == IDX_W'(i))
            text[8*i +: 8] <= chr_byte;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) upd <= 1'b0;
      else        upd <= hex_ld | chr_ld;
   end

   a_r14_upd_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (hex_ld || chr_ld) |=> upd);
   a_r14_upd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !(hex_ld || chr_ld) |=> (!upd && $stable(text)));
endmodule

// File: rtl/brd_i2c_regs.sv
module brd_i2c_regs #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_out,
   input  logic              wr_oe,
   input  logic              wr_sel,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] out_q,
   output logic [1:0]        oe_q,
   output logic              sel_q,
   output logic              scl_out,
   output logic              sda_out
);
   import brd_ctrl_pkg::*;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q <= DATA_W'(I2C_OUT_RST);
         oe_q  <= 2'b00;
         sel_q <= 1'b1;
      end else begin
         if (wr_out) out_q <= wdata;
         if (wr_oe)  oe_q  <= wdata[1:0];
         if (wr_sel) sel_q <= wdata[0];
      end
   end

   assign scl_out = out_q[1];
   assign sda_out = out_q[0];

   a_r10_pins_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_out |=> ($stable(scl_out) && $stable(sda_out)));
   a_r10_pins_load: assert property (@(posedge clk) disable iff (!rst_n)
      wr_out |=> (scl_out == $past(wdata[1]) && sda_out == $past(wdata[0])));
endmodule

// File: rtl/brd_ctrl_regs.sv
module brd_ctrl_regs #(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int DEC_W      = 20,
   parameter int N_CHARS    = 8,
   parameter bit BIG_ENDIAN = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   input  logic                 req_write,
   input  logic [ADDR_W-1:0]    req_addr,
   input  logic [DATA_W-1:0]    req_wdata,
   output logic                 rd_valid,
   output logic [DATA_W-1:0]    rd_data,
   output logic [7:0]           led_bar,
   output logic [8*N_CHARS-1:0] disp_text,
   output logic                 disp_upd,
   output logic                 soft_rst_req,
   output logic [7:0]           brk_val,
   output logic [7:0]           gp_out,
   output logic                 scl_out,
   output logic                 sda_out,
   output logic [1:0]           i2c_oe,
   input  logic                 sda_in
);
   import brd_ctrl_pkg::*;

   localparam int IDX_W = $clog2(N_CHARS);
   localparam logic [DEC_W-1:0] A_SW    = DEC_W'(OFF_SWITCH);
   localparam logic [DEC_W-1:0] A_STAT  = DEC_W'(OFF_STATUS);
   localparam logic [DEC_W-1:0] A_LED   = DEC_W'(OFF_LED);
   localparam logic [DEC_W-1:0] A_HEX   = DEC_W'(OFF_HEXWORD);
   localparam logic [DEC_W-1:0] A_CH0   = DEC_W'(OFF_CHAR0);
   localparam logic [DEC_W-1:0] A_CHN   = DEC_W'(OFF_CHAR0 + CHAR_STRIDE*(N_CHARS-1));
   localparam logic [DEC_W-1:0] A_SRST  = DEC_W'(OFF_SOFTRST);
   localparam logic [DEC_W-1:0] A_BRK   = DEC_W'(OFF_BREAK);
   localparam logic [DEC_W-1:0] A_GPO   = DEC_W'(OFF_GPO);
   localparam logic [DEC_W-1:0] A_GPI   = DEC_W'(OFF_GPI);
   localparam logic [DEC_W-1:0] A_I2CI  = DEC_W'(OFF_I2C_IN);
   localparam logic [DEC_W-1:0] A_I2COE = DEC_W'(OFF_I2C_OE);
   localparam logic [DEC_W-1:0] A_I2CO  = DEC_W'(OFF_I2C_OUT);
   localparam logic [DEC_W-1:0] A_I2CS  = DEC_W'(OFF_I2C_SEL);

   // Elaboration checks
   if (DATA_W != 4*N_CHARS) begin : g_bad_width
      $error("DATA_W must equal 4*N_CHARS");
   end
   if (N_CHARS < 2 || DEC_W < 12 || DEC_W >= ADDR_W) begin : g_bad_geom
      $error("N_CHARS >= 2 and 12 <= DEC_W < ADDR_W required");
   end

   logic [DEC_W-1:0] off;
   logic             unused_hi;
   assign off       = req_addr[DEC_W-1:0];
   assign unused_hi = ^req_addr[ADDR_W-1:DEC_W];

   logic wr_fire, rd_fire;
   assign wr_fire = req_valid &  req_write;
   assign rd_fire = req_valid & ~req_write;

   // Status value variant
   logic [7:0] stat_val;
   if (BIG_ENDIAN) begin : g_be
      assign stat_val = 8'h12;
   end else begin : g_le
      assign stat_val = 8'h10;
   end

   // Character window decode
   logic [DEC_W-1:0] ch_rel;
   logic             ch_hit;
   logic [IDX_W-1:0] ch_idx;
   assign ch_rel = off - A_CH0;
   assign ch_hit = (off >= A_CH0) && (off <= A_CHN) && (ch_rel[2:0] == 3'b000);
   assign ch_idx = ch_rel[3 +: IDX_W];

   // Plain byte registers
   logic [7:0] led_q, brk_q, gpo_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         led_q        <= 8'h00;
         brk_q        <= BREAK_RST;
         gpo_q        <= 8'h00;
         soft_rst_req <= 1'b0;
      end else begin
         if (wr_fire && off == A_LED) led_q <= req_wdata[7:0];
         if (wr_fire && off == A_BRK) brk_q <= req_wdata[7:0];
         if (wr_fire && off == A_GPO) gpo_q <= req_wdata[7:0];
         soft_rst_req <= wr_fire && off == A_SRST && req_wdata == DATA_W'(SOFT_MAGIC);
      end
   end
   assign led_bar = led_q;
   assign brk_val = brk_q;
   assign gp_out  = gpo_q;

   // Display
   logic [8*N_CHARS-1:0] hex_chars;
   brd_hex_fmt #(.N_CHARS(N_CHARS)) hex_i (
      .word (req_wdata),
      .chars(hex_chars)
   );

   brd_disp_buf #(.N_CHARS(N_CHARS)) disp_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .hex_ld   (wr_fire && off == A_HEX),
      .hex_chars(hex_chars),
      .chr_ld   (wr_fire && ch_hit),
      .chr_idx  (ch_idx),
      .chr_byte (req_wdata[7:0]),
      .text     (disp_text),
      .upd      (disp_upd)
   );

   // I2C bit-bang registers
   logic [DATA_W-1:0] i2c_out_q;
   logic              i2c_sel_q;
   brd_i2c_regs #(.DATA_W(DATA_W)) i2c_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_out (wr_fire && off == A_I2CO),
      .wr_oe  (wr_fire && off == A_I2COE),
      .wr_sel (wr_fire && off == A_I2CS),
      .wdata  (req_wdata),
      .out_q  (i2c_out_q),
      .oe_q   (i2c_oe),
      .sel_q  (i2c_sel_q),
      .scl_out(scl_out),
      .sda_out(sda_out)
   );

   // Read mux from registered state
   logic [DATA_W-1:0] rd_mux;
   always_comb begin
      case (off)
         A_SW:    rd_mux = '0;
         A_STAT:  rd_mux = DATA_W'(stat_val);
         A_LED:   rd_mux = DATA_W'(led_q);
         A_BRK:   rd_mux = DATA_W'(brk_q);
         A_GPO:   rd_mux = DATA_W'(gpo_q);
         A_GPI:   rd_mux = i2c_sel_q ? i2c_out_q : '0;
         A_I2CI:  rd_mux = DATA_W'({I2C_IN_RST[1], sda_in});
         A_I2COE: rd_mux = DATA_W'(i2c_oe);
         A_I2CO:  rd_mux = i2c_out_q;
         A_I2CS:  rd_mux = DATA_W'(i2c_sel_q);
         default: rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= rd_fire;
         rd_data  <= rd_fire ? rd_mux : '0;
      end
   end

   a_r3_rd_valid_on: assert property (@(posedge clk) disable iff (!rst_n)
      rd_fire |=> rd_valid);
   a_r3_rd_valid_off: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_fire |=> !rd_valid);
   a_r8_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst_req |=> !soft_rst_req);
   a_r8_magic_only: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(soft_rst_req) |-> ($past(req_wdata) == DATA_W'(SOFT_MAGIC) && $past(wr_fire)));
   a_r5_led_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_fire && off == A_LED) |=> $stable(led_bar));
endmodule

// File: tb/brd_ctrl_regs_tb.sv
module brd_ctrl_regs_tb_top;
   localparam bit BE = 1'b1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [31:0] req_addr = '0, req_wdata = '0;
   logic        rd_valid;
   logic [31:0] rd_data;
   logic [7:0]  led_bar, brk_val, gp_out;
   logic [63:0] disp_text;
   logic        disp_upd, soft_rst_req, scl_out, sda_out, sda_in = 1'b1;
   logic [1:0]  i2c_oe;

   always #2 clk = ~clk;   // 250 MHz

   brd_ctrl_regs #(.BIG_ENDIAN(BE)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid),
      .rd_data(rd_data), .led_bar(led_bar), .disp_text(disp_text),
      .disp_upd(disp_upd), .soft_rst_req(soft_rst_req), .brk_val(brk_val),
      .gp_out(gp_out), .scl_out(scl_out), .sda_out(sda_out),
      .i2c_oe(i2c_oe), .sda_in(sda_in)
   );

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;
   logic [31:0] exp_q[$];
   string       tag_q[$];
   logic [7:0]  exp_ch [8];

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] hexc(input logic [3:0] n);
      return (n < 10) ? 8'h30 + 8'(n) : 8'h37 + 8'(n);
   endfunction

   function automatic logic [63:0] model_text();
      logic [63:0] t;
      for (int i = 0; i < 8; i++) t[8*i +: 8] = exp_ch[i];
      return t;
   endfunction

   // Monitor: pops expected read data when the design returns it
   always @(negedge clk) begin
      if (rst_n && rd_valid) begin
         if (exp_q.size() == 0) chk(1'b0, "R3 unexpected rd_valid", 64'(rd_data), 64'h0);
         else begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(rd_data === e, t, 64'(rd_data), 64'(e));
         end
      end
   end

   task automatic wr(input logic [31:0] a, input logic [31:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
   endtask

   task automatic rd(input logic [31:0] a, input logic [31:0] e, input string tag);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = a;
      exp_q.push_back(e); tag_q.push_back(tag);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic chk_text(input string tag);
      chk(disp_text === model_text(), tag, disp_text, model_text());
   endtask

   initial begin
      for (int i = 0; i < 8; i++) exp_ch[i] = 8'h20;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R13 / R9 reset state
      chk(led_bar === 8'h00, "R13 led reset", 64'(led_bar), 64'h0);
      chk_text("R13 display spaces");
      chk({scl_out, sda_out} === 2'b11, "R13 i2c out reset", 64'({scl_out, sda_out}), 64'h3);
      chk(i2c_oe === 2'b00, "R13 oe reset", 64'(i2c_oe), 64'h0);
      chk(soft_rst_req === 1'b0, "R13 softreset idle", 64'(soft_rst_req), 64'h0);
      chk(brk_val === 8'h0A && gp_out === 8'h00, "R9 brk/gpo reset", 64'({brk_val, gp_out}), 64'h0A00);
      chk(rd_valid === 1'b0, "R3 idle rd_valid", 64'(rd_valid), 64'h0);
      rd(32'h0000_0B18, 32'h1, "R13 select reset");
      rd(32'h0000_0B10, 32'h3, "R13 i2c out readback");
      // R4
      rd(32'h0000_0200, 32'h0, "R4 switch");
      rd(32'h0000_0208, BE ? 32'h12 : 32'h10, "R4 status");
      // R5
      wr(32'h0000_0408, 32'h0000_01FF);
      chk(led_bar === 8'hFF, "R5 led low byte", 64'(led_bar), 64'hFF);
      chk(rd_valid === 1'b0, "R3 no rd_valid after write", 64'(rd_valid), 64'h0);
      rd(32'h0000_0408, 32'hFF, "R5 led read");
      // R1 aliasing
      wr(32'hABC0_0408, 32'h0000_005A);
      chk(led_bar === 8'h5A, "R1 alias write", 64'(led_bar), 64'h5A);
      rd(32'hFFF0_0408, 32'h5A, "R1 alias read");
      // R2 unmapped
      wr(32'h0000_0404, 32'h77);
      wr(32'h0000_0200, 32'h77);
      chk(led_bar === 8'h5A, "R2 unmapped write", 64'(led_bar), 64'h5A);
      rd(32'h0000_0404, 32'h0, "R2 unmapped read");
      rd(32'h0000_0200, 32'h0, "R2 switch after write");
      // R6 hex word
      wr(32'h0000_0410, 32'h0123_ABCD);
      for (int i = 0; i < 8; i++) exp_ch[i] = hexc(4'(32'h0123_ABCD >> (28 - 4*i)));
      chk_text("R6 hex 0123ABCD");
      chk(disp_upd === 1'b1, "R14 upd after hex", 64'(disp_upd), 64'h1);
      @(negedge clk);
      chk(disp_upd === 1'b0, "R14 upd single", 64'(disp_upd), 64'h0);
      wr(32'h0000_0410, 32'hFEDC_9876);
      for (int i = 0; i < 8; i++) exp_ch[i] = hexc(4'(32'hFEDC_9876 >> (28 - 4*i)));
      chk_text("R6 hex FEDC9876");
      // R7 characters
      wr(32'h0000_0430, 32'h1234_5641);
      exp_ch[3] = 8'h41;
      chk_text("R7 char pos3");
      chk(disp_upd === 1'b1, "R14 upd after char", 64'(disp_upd), 64'h1);
      wr(32'h0000_0450, 32'h0000_007A);
      exp_ch[7] = 8'h7A;
      chk_text("R7 char pos7");
      wr(32'h0000_0418, 32'h0000_0030);
      exp_ch[0] = 8'h30;
      chk_text("R7 char pos0");
      wr(32'h0000_041C, 32'h0000_0021);
      chk_text("R2 misaligned char offset");
      chk(disp_upd === 1'b0, "R14 no upd misaligned", 64'(disp_upd), 64'h0);
      // R8 soft reset
      wr(32'h0000_0500, 32'h43);
      chk(soft_rst_req === 1'b0, "R8 wrong value", 64'(soft_rst_req), 64'h0);
      wr(32'h0000_0500, 32'h142);
      chk(soft_rst_req === 1'b0, "R8 upper bits set", 64'(soft_rst_req), 64'h0);
      wr(32'h0000_0500, 32'h42);
      chk(soft_rst_req === 1'b1, "R8 magic pulse", 64'(soft_rst_req), 64'h1);
      @(negedge clk);
      chk(soft_rst_req === 1'b0, "R8 pulse one cycle", 64'(soft_rst_req), 64'h0);
      // R9
      wr(32'h0000_0508, 32'h3C5);
      wr(32'h0000_0A00, 32'hA5);
      chk(brk_val === 8'hC5 && gp_out === 8'hA5, "R9 brk/gpo write", 64'({brk_val, gp_out}), 64'hC5A5);
      rd(32'h0000_0508, 32'hC5, "R9 brk read");
      rd(32'h0000_0A00, 32'hA5, "R9 gpo read");
      // R10 / R12
      wr(32'h0000_0B10, 32'hDEAD_BEE2);
      chk({scl_out, sda_out} === 2'b10, "R10 scl/sda", 64'({scl_out, sda_out}), 64'h2);
      rd(32'h0000_0B10, 32'hDEAD_BEE2, "R10 out readback");
      rd(32'h0000_0A08, 32'hDEAD_BEE2, "R12 gpi sel=1");
      wr(32'h0000_0B08, 32'hF);
      chk(i2c_oe === 2'b11, "R10 oe", 64'(i2c_oe), 64'h3);
      rd(32'h0000_0B08, 32'h3, "R10 oe read");
      wr(32'h0000_0B18, 32'h0);
      rd(32'h0000_0A08, 32'h0, "R12 gpi sel=0");
      wr(32'h0000_0B18, 32'h3);
      rd(32'h0000_0B18, 32'h1, "R10 sel read");
      // R11
      sda_in = 1'b0;
      rd(32'h0000_0B00, 32'h2, "R11 sda low");
      sda_in = 1'b1;
      rd(32'h0000_0B00, 32'h3, "R11 sda high");
      wr(32'h0000_0B00, 32'h0);
      rd(32'h0000_0B00, 32'h3, "R11 write ignored");
      repeat (3) @(negedge clk);
      chk(exp_q.size() == 0, "R3 all reads returned", 64'(exp_q.size()), 64'h0);
      done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (20000) @(posedge clk);
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
         end
      join_any
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule